// File: doc/BRIEF.md
# Multi-Mode 8-Bit Timer/Counter

The block is an 8-bit up-counter with a selectable count source and three operating modes. The counter advances on a count enable taken from a tap of a free-running prescaler, or from rising edges of an external count input. In timer mode the counter runs up to a compare value, then clears. Each such match flips a square-wave output and raises a one-cycle interrupt request. In PWM mode the counter wraps freely and a pulse-width output is derived from the compare value. In capture mode a single-cycle strobe copies the running count into a capture register.

Software reaches the block through a small synchronous register bus. The bus carries a write strobe, a 2-bit address, write data, and read data that is decoded combinationally from the registered state. Address 0 is control, 1 is compare, 2 is the counter (read only) and 3 is the capture register (read only).

Top module: `mm_timer8`

## Requirements
- R1: After reset, every register reads 0 and the toggle, PWM and interrupt outputs are 0.
- R2: A write at address 1 sets the compare value. A write at address 0 sets control: bit 7 enable, bits 5:4 mode, bits 3:1 source select. Bit 0 is a clear strobe. Address 0 reads back {enable, 0, mode, select, 0}.
- R3: Select codes 0 to 6 give a count enable every 2, 4, 8, 32, 128, 512 or 2048 clocks of the enabled prescaler, which starts from 0 when enabled.
- R4: Select code 7 counts each rising edge of the external input once. The count lands on the third clock edge after the input is first sampled high.
- R5: In timer mode (mode 00), a count enable while the counter equals the compare value clears the counter to 0 instead of incrementing it.
- R6: Every match raises the interrupt output for exactly one cycle, in the cycle after the match edge. There is no interrupt in the other modes.
- R7: The toggle output inverts on every match and holds otherwise while enabled.
- R8: Writing control with bit 0 set clears the counter on that edge, taking priority over a count enable on the same edge.
- R9: In PWM mode (mode 01) the counter wraps 255 to 0. The PWM output is high, one cycle later, while the counter is below the compare value, so a compare value of 0 keeps it low.
- R10: In capture mode (mode 10 or 11) a strobe loads the current counter into the capture register. In other modes the strobe leaves the capture register unchanged.
- R11: While disabled, the counter and prescaler are held at 0 and the toggle, PWM and interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for write and read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| ext_cnt_i | input | 1 | External count input (asynchronous) |
| cap_stb_i | input | 1 | Single-cycle capture strobe |
| tog_o | output | 1 | Toggle output |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Match interrupt request pulse |

## Verification
Register writes, counter clears and captures take effect on the clock edge that samples them, so the next read shows them. The interrupt pulse, the toggle and the PWM level are registered one edge after the state they depend on. An external edge needs three edges to reach the counter: two synchronizer stages and then the count. A cycle model in the bench applies the same inputs on each rising edge. At the following falling edge it compares all outputs and the read data, so every expected value is taken in the cycle it is due. The directed counts of interrupts, toggles and PWM-high cycles are taken over windows that hold whole periods.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NTAP = 7;
    localparam logic [2:0] SEL_EXT = 3'd7;
    localparam logic [1:0] A_CTL = 2'd0;
    localparam logic [1:0] A_CMP = 2'd1;
    localparam logic [1:0] A_CNT = 2'd2;
    localparam logic [1:0] A_CAP = 2'd3;
    localparam logic [1:0] MD_TIMER = 2'b00;
    localparam logic [1:0] MD_PWM   = 2'b01;

    typedef struct packed {
        logic       en;
        logic [1:0] mode;
        logic [2:0] sel;
    } ctl_t;

    // number of low prescaler bits that must all be one for a tap to fire
    function automatic int tap_w(input int idx);
        case (idx)
            0: return 1;
            1: return 2;
            2: return 3;
            3: return 5;
            4: return 7;
            5: return 9;
            default: return 11;
        endcase
    endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int PW = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [2:0] sel_i,
    output logic       tick_o
);
    typedef struct packed {
        logic [PW-1:0] pre;
    } st_t;

    st_t s_d, s_q;
    logic [7:0] tk;

    generate
        for (genvar g = 0; g < NTAP; g++) begin : g_tap
            assign tk[g] = &s_q.pre[tap_w(g)-1:0];
        end
    endgenerate
    assign tk[7] = 1'b0;

    always_comb begin
        s_d = s_q;
        s_d.pre = en_i ? s_q.pre + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_o = en_i && (sel_i != SEL_EXT) && tk[sel_i];
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic rise_o
);
    localparam int SH = STAGES + 1;

    typedef struct packed {
        logic [SH-1:0] sh;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.sh = {s_q.sh[SH-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise_o = s_q.sh[SH-2] & ~s_q.sh[SH-1];
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [1:0]    addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          cnt_en_i,
    input  logic          capt_i,
    output ctl_t          ctl_o,
    output logic [DW-1:0] cmp_o,
    output logic [DW-1:0] cnt_o,
    output logic [DW-1:0] cap_o,
    output logic          tog_o,
    output logic          pwm_o,
    output logic          irq_o
);
    typedef struct packed {
        ctl_t          ctl;
        logic [DW-1:0] cmp;
        logic [DW-1:0] cnt;
        logic [DW-1:0] cap;
        logic          tog;
        logic          pwm;
        logic          irq;
    } st_t;

    st_t  s_d, s_q;
    logic clr;

    assign clr = we_i && (addr_i == A_CTL) && wdata_i[0];

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        s_d.pwm = 1'b0;
        if (!s_q.ctl.en) begin
            s_d.cnt = '0;
            s_d.tog = 1'b0;
        end else begin
            s_d.pwm = (s_q.ctl.mode == MD_PWM) && (s_q.cnt < s_q.cmp);
            if (clr) begin
                s_d.cnt = '0;
            end else if (cnt_en_i) begin
                if ((s_q.ctl.mode == MD_TIMER) && (s_q.cnt == s_q.cmp)) begin
                    s_d.cnt = '0;
                    s_d.tog = ~s_q.tog;
                    s_d.irq = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            if (s_q.ctl.mode[1] && capt_i) s_d.cap = s_q.cnt;
        end
        if (we_i) begin
            case (addr_i)
                A_CTL: begin
                    s_d.ctl.en   = wdata_i[7];
                    s_d.ctl.mode = wdata_i[5:4];
                    s_d.ctl.sel  = wdata_i[3:1];
                end
                A_CMP:   s_d.cmp = wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctl_o = s_q.ctl;
    assign cmp_o = s_q.cmp;
    assign cnt_o = s_q.cnt;
    assign cap_o = s_q.cap;
    assign tog_o = s_q.tog;
    assign pwm_o = s_q.pwm;
    assign irq_o = s_q.irq;
endmodule

// File: rtl/mm_timer8.sv
module mm_timer8
    import tmr_pkg::*;
#(
    parameter int DW     = 8,
    parameter int PW     = 11,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          ext_cnt_i,
    input  logic          cap_stb_i,
    output logic          tog_o,
    output logic          pwm_o,
    output logic          irq_o
);
    ctl_t          ctl_w;
    logic [DW-1:0] cmp_w, cnt_w, cap_w;
    logic          pre_tick, ext_rise, cnt_en;

    tmr_prescale #(.PW(PW)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (ctl_w.en),
        .sel_i  (ctl_w.sel),
        .tick_o (pre_tick)
    );

    tmr_edge #(.STAGES(STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_i    (ext_cnt_i),
        .rise_o (ext_rise)
    );

    assign cnt_en = (ctl_w.sel == SEL_EXT) ? ext_rise : pre_tick;

    tmr_core #(.DW(DW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (bus_we),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .cnt_en_i (cnt_en),
        .capt_i   (cap_stb_i),
        .ctl_o    (ctl_w),
        .cmp_o    (cmp_w),
        .cnt_o    (cnt_w),
        .cap_o    (cap_w),
        .tog_o    (tog_o),
        .pwm_o    (pwm_o),
        .irq_o    (irq_o)
    );

    always_comb begin
        case (bus_addr)
            A_CTL:   bus_rdata = DW'({ctl_w.en, 1'b0, ctl_w.mode, ctl_w.sel, 1'b0});
            A_CMP:   bus_rdata = cmp_w;
            A_CNT:   bus_rdata = cnt_w;
            default: bus_rdata = cap_w;
        endcase
    end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          we,
    input logic [1:0]    addr,
    input logic [DW-1:0] wdata,
    input logic          capt,
    input logic          en,
    input logic [1:0]    mode,
    input logic [DW-1:0] cmp,
    input logic [DW-1:0] cnt,
    input logic [DW-1:0] cap,
    input logic          tog,
    input logic          pwm,
    input logic          irq
);
    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R7
    tog_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ((tog != $past(tog)) == irq));

    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0 && !tog && !pwm && !irq));

    // R8
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == 2'd0 && wdata[0]) |=> (cnt == '0));

    // R9
    pwm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp == '0) |=> !pwm);

    // R10
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && mode[1] && capt) |=> $stable(cap));
endmodule

bind mm_timer8 tmr_chk #(.DW(DW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bus_we),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .capt  (cap_stb_i),
    .en    (ctl_w.en),
    .mode  (ctl_w.mode),
    .cmp   (cmp_w),
    .cnt   (cnt_w),
    .cap   (cap_w),
    .tog   (tog_o),
    .pwm   (pwm_o),
    .irq   (irq_o)
);

// File: tb/sim_mm_timer8.sv
module sim_mm_timer8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic       ext = 1'b0;
    logic       capt = 1'b0;
    logic [7:0] rdata;
    logic       tog, pwm, irq;

    always #4 clk = ~clk;

    mm_timer8 u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .ext_cnt_i (ext),
        .cap_stb_i (capt),
        .tog_o     (tog),
        .pwm_o     (pwm),
        .irq_o     (irq)
    );

    int nchk = 0, nfail = 0;
    int nirq = 0, ntog = 0, npwm = 0;
    logic prev_tog = 1'b0;
    bit done = 1'b0;

    // reference model state
    logic       m_en = 0;
    logic [1:0] m_mode = 0;
    logic [2:0] m_sel = 0;
    logic [7:0] m_cmp = 0, m_cnt = 0, m_cap = 0;
    logic       m_tog = 0, m_pwm = 0, m_irq = 0;
    logic [10:0] m_pre = 0;
    logic       e1 = 0, e2 = 0, e3 = 0;

    task automatic chk(input string tag, input int got, input int exp);
        nchk++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int divof(input logic [2:0] s);
        case (s)
            3'd0: return 2;
            3'd1: return 4;
            3'd2: return 8;
            3'd3: return 32;
            3'd4: return 128;
            3'd5: return 512;
            default: return 2048;
        endcase
    endfunction

    function automatic logic [7:0] ctlb(input logic en, input logic [1:0] md,
                                        input logic [2:0] sel, input logic clr);
        return {en, 1'b0, md, sel, clr};
    endfunction

    function automatic logic [7:0] m_rd(input logic [1:0] a);
        case (a)
            2'd0: return {m_en, 1'b0, m_mode, m_sel, 1'b0};
            2'd1: return m_cmp;
            2'd2: return m_cnt;
            default: return m_cap;
        endcase
    endfunction

    task automatic model_step();
        logic tick, ce, clr;
        logic [7:0] ncnt, ncap;
        logic ntg, npw, nir;
        tick = m_en && (m_sel != 3'd7) &&
               ((int'(m_pre) % divof(m_sel)) == divof(m_sel) - 1);
        ce   = (m_sel == 3'd7) ? (e2 && !e3) : tick;
        clr  = we && (addr == 2'd0) && wdata[0];
        ncnt = m_cnt; ncap = m_cap; ntg = m_tog; npw = 1'b0; nir = 1'b0;
        if (!m_en) begin
            ncnt = 8'd0;
            ntg  = 1'b0;
        end else begin
            npw = (m_mode == 2'b01) && (m_cnt < m_cmp);
            if (clr) ncnt = 8'd0;
            else if (ce) begin
                if (m_mode == 2'b00 && m_cnt == m_cmp) begin
                    ncnt = 8'd0; ntg = !m_tog; nir = 1'b1;
                end else ncnt = m_cnt + 8'd1;
            end
            if (m_mode[1] && capt) ncap = m_cnt;
        end
        m_pre = m_en ? m_pre + 11'd1 : 11'd0;
        m_cnt = ncnt; m_cap = ncap; m_tog = ntg; m_pwm = npw; m_irq = nir;
        if (we) begin
            if (addr == 2'd0) begin
                m_en = wdata[7]; m_mode = wdata[5:4]; m_sel = wdata[3:1];
            end else if (addr == 2'd1) m_cmp = wdata;
        end
        e3 = e2; e2 = e1; e1 = ext;
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R6 irq", irq, m_irq);
        chk("R7 tog", tog, m_tog);
        chk("R9 pwm", pwm, m_pwm);
        chk("R2 rdata", rdata, m_rd(addr));
        if (irq) nirq++;
        if (tog != prev_tog) ntog++;
        prev_tog = tog;
        if (pwm) npwm++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        we = 1'b1; addr = a; wdata = d;
        cyc();
        we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input int exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 4; a++) rd_chk("R1 reset reg", 2'(a), 0);
        chk("R1 reset tog", tog, 0);
        chk("R1 reset pwm", pwm, 0);
        chk("R1 reset irq", irq, 0);

        // R2 register access
        wr(2'd1, 8'hA5);
        rd_chk("R2 cmp readback", 2'd1, 8'hA5);
        wr(2'd0, ctlb(1'b0, 2'b11, 3'd5, 1'b0));
        rd_chk("R2 ctl readback", 2'd0, 8'h3A);

        // R3 divide by 8
        wr(2'd1, 8'd255);
        wr(2'd0, ctlb(1'b1, 2'b00, 3'd2, 1'b0));
        addr = 2'd2;
        idle(80);
        rd_chk("R3 div8 count", 2'd2, 10);

        // R11 disable
        wr(2'd0, ctlb(1'b0, 2'b00, 3'd2, 1'b0));
        addr = 2'd2;
        idle(1);
        rd_chk("R11 disabled cnt", 2'd2, 0);
        chk("R11 disabled tog", tog, 0);

        // R5 R6 R7 match at compare 3, divide by 2
        wr(2'd1, 8'd3);
        wr(2'd0, ctlb(1'b1, 2'b00, 3'd0, 1'b0));
        addr = 2'd2;
        nirq = 0; ntog = 0;
        idle(80);
        chk("R6 irq pulses", nirq, 10);
        chk("R7 toggles", ntog, 10);
        chk("R7 tog level", tog, 0);
        rd_chk("R5 wrapped cnt", 2'd2, 0);
        idle(6);
        rd_chk("R5 cnt at compare", 2'd2, 3);

        // R4 external edges
        wr(2'd1, 8'd255);
        wr(2'd0, ctlb(1'b1, 2'b00, 3'd7, 1'b1));
        addr = 2'd2;
        for (int p = 0; p < 3; p++) begin
            ext = 1'b1; idle(2);
            ext = 1'b0; idle(2);
        end
        idle(2);
        rd_chk("R4 ext count", 2'd2, 3);

        // R8 clear collides with a pending external count
        ext = 1'b1; idle(2);
        ext = 1'b0;
        wr(2'd0, ctlb(1'b1, 2'b00, 3'd7, 1'b1));
        rd_chk("R8 clear wins", 2'd2, 0);
        idle(3);
        rd_chk("R8 after clear", 2'd2, 0);

        // R9 PWM
        wr(2'd1, 8'd0);
        wr(2'd0, ctlb(1'b1, 2'b01, 3'd0, 1'b0));
        npwm = 0;
        idle(600);
        chk("R9 pwm compare 0", npwm, 0);
        wr(2'd1, 8'd64);
        idle(20);
        npwm = 0;
        idle(512);
        chk("R9 pwm high cycles", npwm, 128);

        // R10 capture
        wr(2'd0, ctlb(1'b1, 2'b10, 3'd0, 1'b0));
        addr = 2'd2;
        idle(37);
        v = rdata;
        capt = 1'b1; addr = 2'd3;
        cyc();
        capt = 1'b0;
        chk("R10 captured", rdata, v);
        wr(2'd0, ctlb(1'b1, 2'b00, 3'd0, 1'b0));
        addr = 2'd3; capt = 1'b1;
        cyc();
        capt = 1'b0;
        cyc();
        chk("R10 strobe ignored in timer mode", rdata, v);
        wr(2'd0, ctlb(1'b1, 2'b11, 3'd0, 1'b0));
        addr = 2'd2;
        idle(5);
        v = rdata;
        capt = 1'b1; addr = 2'd3;
        cyc();
        capt = 1'b0;
        chk("R10 captured mode 11", rdata, v);

        // constrained random traffic
        for (int i = 0; i < 5000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            we = 1'b0; capt = 1'b0;
            if (r < 2) begin
                logic [2:0] s;
                logic [1:0] k;
                k = 2'($urandom_range(0, 3));
                s = (k == 2'd3) ? 3'd7 : 3'(k);
                we = 1'b1; addr = 2'd0;
                wdata = ctlb($urandom_range(0, 7) != 0, 2'($urandom_range(0, 3)),
                             s, $urandom_range(0, 3) == 0);
            end else if (r < 4) begin
                we = 1'b1; addr = 2'd1;
                wdata = ($urandom_range(0, 7) == 0) ? 8'd255 : 8'($urandom_range(0, 40));
            end else begin
                addr = 2'($urandom_range(0, 3));
            end
            if ($urandom_range(0, 2) == 0) ext = ~ext;
            if ($urandom_range(0, 15) == 0) capt = 1'b1;
            cyc();
        end
        we = 1'b0; capt = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule